// File: doc/BRIEF.md
# Register Write-Pending Scoreboard

This block tracks, for every architectural register, whether a write to it is still outstanding. When an instruction issues to an execution unit and that instruction will produce a register result, the destination register is marked pending. The mark is removed when the register file write port stores that register. It is also removed when the unit finishes without producing a result: each unit remembers at issue time whether it promised a write, and that memory releases the register the promise would otherwise have left stuck.

An instruction trying to issue presents its source registers on the check ports. The hazard output goes high when any enabled source register is still pending, and the issue logic holds the instruction back. Register selects on every port are either binary indices or one-hot vectors, fixed by a parameter. Set, clear and check requests from several requesters are each merged by OR before they touch the pending vector.

Top module: `wr_pending_board`

## Requirements
- R1: Reset (active-low `rst_n`) clears every pending bit, so no check reports a hazard after reset.
- R2: When `iss_go[u]` and `iss_wr[u]` are both high at a clock edge, the bit of register `iss_dst[u]` is pending from the next cycle on.
- R3: An issue with `iss_wr[u]` low marks no register pending.
- R4: When `wb_grant[u]` is high at a clock edge, the bit of register `wb_dst[u]` is cleared from the next cycle on.
- R5: Each unit latches `iss_wr` and the destination at issue. If the unit then raises `unit_done` while that latched flag is set and `unit_res_ok` is low, the latched destination's bit is cleared at that edge.
- R6: A completion with `unit_res_ok` high does not clear a bit through the latched flag, and the latched flag returns to zero at any edge where `unit_busy` is low and no issue occurs, so a later completion does not clear anything.
- R7: When the same bit is set and cleared at the same edge, it ends up pending.
- R8: The check port `k` selects a source only while `chk_active` and `chk_rd[k]` are both high; otherwise it cannot raise `hazard_o`.
- R9: `hazard_o` is combinational: it is the OR over all enabled check ports of the pending bit of `chk_src[k]`, in the same cycle.
- R10: Requests from different units on the set port, and on the clear port, at the same edge all take effect together.
- R11: With `ONEHOT`=0 a select field holds a binary register index (bit `i` of the decoded vector is set when the field equals `i`); with `ONEHOT`=1 the field is the `NREGS`-bit vector itself, bit `i` naming register `i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_go | input | N_UNIT | Unit is selected and issued this cycle |
| iss_wr | input | N_UNIT | Issued instruction will write a register |
| iss_dst | input | N_UNIT*SELW | Destination select per unit (field u at [u*SELW +: SELW]) |
| unit_busy | input | N_UNIT | Unit holds an instruction |
| unit_done | input | N_UNIT | Unit completes this cycle |
| unit_res_ok | input | N_UNIT | Completing unit produced a register result |
| wb_grant | input | N_UNIT | Register file write port writes this unit's result |
| wb_dst | input | N_UNIT*SELW | Register written per unit |
| chk_active | input | 1 | An instruction is attempting issue |
| chk_rd | input | N_CHK | Source operand k is read |
| chk_src | input | N_CHK*SELW | Source select per check port |
| hazard_o | output | 1 | Some enabled source register is pending |

## Verification
The bench builds two copies side by side with eight registers, two units and two check ports, one with binary selects (three-bit fields) and one with one-hot selects, and drives both with the same register choices. Eight registers make it possible to sweep every destination through set, write-port release and no-result release, and after each step to probe every register, so a wrong bit, a leaked neighbour or a decode error in either encoding shows up. Two units and two check ports bring same-edge set-against-clear, simultaneous requesters and per-port read gating within reach.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
    // Width of a register select field for the chosen encoding.
    function automatic int wpb_selw(input bit onehot, input int nregs);
        int w;
        if (onehot) begin
            w = nregs;
        end else begin
            w = (nregs > 1) ? $clog2(nregs) : 1;
        end
        return w;
    endfunction
endpackage

// File: rtl/wpb_sel_decode.sv
module wpb_sel_decode import wpb_pkg::*; #(
    parameter int NREGS  = 8,
    parameter bit ONEHOT = 1'b0,
    parameter int SELW   = wpb_selw(ONEHOT, NREGS)
) (
    input  logic             en,
    input  logic [SELW-1:0]  sel,
    output logic [NREGS-1:0] vec
);
    generate
        if (ONEHOT) begin : g_onehot
            // Vector passes through, gated by the enable.
            always_comb begin
                vec = en ? sel : '0;
            end
        end else begin : g_binary
            // Index compare per bit; safe for non power-of-two sizes.
            always_comb begin
                for (int i = 0; i < NREGS; i++) begin
                    vec[i] = en && (sel == SELW'(i));
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wpb_unit_intent.sv
module wpb_unit_intent #(
    parameter int NREGS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             wrflag,
    input  logic [NREGS-1:0] dst_vec,
    input  logic             busy,
    input  logic             done,
    input  logic             res_ok,
    output logic [NREGS-1:0] orphan_clr
);
    typedef struct packed {
        logic             intent;
        logic [NREGS-1:0] dst;
    } intent_t;

    intent_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!busy) begin
            s_d.intent = 1'b0;
        end
        if (issue) begin
            s_d.intent = wrflag;
            s_d.dst    = dst_vec;
        end
        orphan_clr = (done && s_q.intent && !res_ok) ? s_q.dst : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wr_pending_board.sv
module wr_pending_board import wpb_pkg::*; #(
    parameter int NREGS  = 8,
    parameter int N_UNIT = 2,
    parameter int N_CHK  = 2,
    parameter bit ONEHOT = 1'b0,
    parameter int SELW   = wpb_selw(ONEHOT, NREGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_UNIT-1:0]       iss_go,
    input  logic [N_UNIT-1:0]       iss_wr,
    input  logic [N_UNIT*SELW-1:0]  iss_dst,
    input  logic [N_UNIT-1:0]       unit_busy,
    input  logic [N_UNIT-1:0]       unit_done,
    input  logic [N_UNIT-1:0]       unit_res_ok,
    input  logic [N_UNIT-1:0]       wb_grant,
    input  logic [N_UNIT*SELW-1:0]  wb_dst,
    input  logic                    chk_active,
    input  logic [N_CHK-1:0]        chk_rd,
    input  logic [N_CHK*SELW-1:0]   chk_src,
    output logic                    hazard_o
);
    typedef struct packed {
        logic [NREGS-1:0] pend;
    } board_t;

    board_t b_d, b_q;

    logic [NREGS-1:0] set_vec    [N_UNIT];
    logic [NREGS-1:0] wb_vec     [N_UNIT];
    logic [NREGS-1:0] orphan_vec [N_UNIT];
    logic [NREGS-1:0] chk_vec    [N_CHK];
    logic [NREGS-1:0] set_all, clr_all, chk_all;
    logic [NREGS-1:0] pend_q;

    // Per-unit set / release paths.
    generate
        for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
            wpb_sel_decode #(.NREGS(NREGS), .ONEHOT(ONEHOT), .SELW(SELW)) u_set_dec (
                .en  (iss_go[u] & iss_wr[u]),
                .sel (iss_dst[u*SELW +: SELW]),
                .vec (set_vec[u])
            );
            wpb_sel_decode #(.NREGS(NREGS), .ONEHOT(ONEHOT), .SELW(SELW)) u_wb_dec (
                .en  (wb_grant[u]),
                .sel (wb_dst[u*SELW +: SELW]),
                .vec (wb_vec[u])
            );
            // The set vector is zero when no write is promised, which is
            // exactly when the latched destination is never used.
            wpb_unit_intent #(.NREGS(NREGS)) u_intent (
                .clk        (clk),
                .rst_n      (rst_n),
                .issue      (iss_go[u]),
                .wrflag     (iss_wr[u]),
                .dst_vec    (set_vec[u]),
                .busy       (unit_busy[u]),
                .done       (unit_done[u]),
                .res_ok     (unit_res_ok[u]),
                .orphan_clr (orphan_vec[u])
            );
        end
        for (genvar k = 0; k < N_CHK; k++) begin : g_chk
            wpb_sel_decode #(.NREGS(NREGS), .ONEHOT(ONEHOT), .SELW(SELW)) u_chk_dec (
                .en  (chk_active & chk_rd[k]),
                .sel (chk_src[k*SELW +: SELW]),
                .vec (chk_vec[k])
            );
        end
    endgenerate

    always_comb begin
        set_all = '0;
        clr_all = '0;
        chk_all = '0;
        for (int u = 0; u < N_UNIT; u++) begin
            set_all = set_all | set_vec[u];
            clr_all = clr_all | wb_vec[u] | orphan_vec[u];
        end
        for (int k = 0; k < N_CHK; k++) begin
            chk_all = chk_all | chk_vec[k];
        end
        // Set is applied after clear so a same-edge new write survives.
        b_d.pend = (b_q.pend & ~clr_all) | set_all;
        hazard_o = |(b_q.pend & chk_all);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign pend_q = b_q.pend;
endmodule

// File: rtl/wpb_chk.sv
module wpb_chk #(
    parameter int NREGS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NREGS-1:0] pend_q,
    input logic [NREGS-1:0] set_all,
    input logic [NREGS-1:0] clr_all,
    input logic             chk_active,
    input logic             hazard_o
);
    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_q == '0));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_all != '0) |=> ((pend_q & $past(set_all)) == $past(set_all)));

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_all & ~set_all) != '0) |=> ((pend_q & $past(clr_all & ~set_all)) == '0));

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_q & ~$past(pend_q) & ~$past(set_all)) == '0));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_active |-> !hazard_o);

    // R9
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> !hazard_o);
endmodule

bind wr_pending_board wpb_chk #(.NREGS(NREGS)) u_wpb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_q     (pend_q),
    .set_all    (set_all),
    .clr_all    (clr_all),
    .chk_active (chk_active),
    .hazard_o   (hazard_o)
);

// File: tb/tb_wr_pending_board.sv
`timescale 1ns/1ps
module tb_wr_pending_board;
    localparam int NR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0] go = '0, wr = '0, busy = '0, done = '0, ok = '0, grant = '0;
    logic [2:0] iss_idx [2];
    logic [2:0] wb_idx  [2];
    logic [2:0] src_idx [2];
    logic       chk_active = 1'b0;
    logic [1:0] chk_rd = '0;

    logic [5:0]  iss_b, wb_b, src_b;
    logic [15:0] iss_h, wb_h, src_h;
    logic        hz_b, hz_h;

    always_comb begin
        iss_b = {iss_idx[1], iss_idx[0]};
        wb_b  = {wb_idx[1],  wb_idx[0]};
        src_b = {src_idx[1], src_idx[0]};
        iss_h = {8'b1 << iss_idx[1], 8'b1 << iss_idx[0]};
        wb_h  = {8'b1 << wb_idx[1],  8'b1 << wb_idx[0]};
        src_h = {8'b1 << src_idx[1], 8'b1 << src_idx[0]};
    end

    wr_pending_board #(.NREGS(NR), .N_UNIT(2), .N_CHK(2), .ONEHOT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .iss_go(go), .iss_wr(wr), .iss_dst(iss_b),
        .unit_busy(busy), .unit_done(done), .unit_res_ok(ok),
        .wb_grant(grant), .wb_dst(wb_b), .chk_active(chk_active),
        .chk_rd(chk_rd), .chk_src(src_b), .hazard_o(hz_b));

    wr_pending_board #(.NREGS(NR), .N_UNIT(2), .N_CHK(2), .ONEHOT(1'b1)) dut_oh (
        .clk(clk), .rst_n(rst_n), .iss_go(go), .iss_wr(wr), .iss_dst(iss_h),
        .unit_busy(busy), .unit_done(done), .unit_res_ok(ok),
        .wb_grant(grant), .wb_dst(wb_h), .chk_active(chk_active),
        .chk_rd(chk_rd), .chk_src(src_h), .hazard_o(hz_h));

    int checks = 0;
    int failures = 0;

    // Bench model built from the requirements.
    logic [NR-1:0] m_pend = '0;
    logic [1:0]    m_int = '0;
    logic [2:0]    m_dst [2];

    task automatic cmp(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Probe register r on check port 0; both encodings must agree (R11).
    task automatic probe(input int r, input string tag);
        chk_active = 1'b1; chk_rd = 2'b01; src_idx[0] = 3'(r);
        #1;
        cmp(hz_b, m_pend[r], {tag, " bin"});
        cmp(hz_h, m_pend[r], {tag, " R11 onehot"});
        chk_active = 1'b0; chk_rd = 2'b00;
    endtask

    task automatic step();
        logic [NR-1:0] s, c;
        s = '0; c = '0;
        for (int u = 0; u < 2; u++) begin
            if (go[u] && wr[u]) s[iss_idx[u]] = 1'b1;
            if (grant[u]) c[wb_idx[u]] = 1'b1;
            if (done[u] && m_int[u] && !ok[u]) c[m_dst[u]] = 1'b1;
        end
        for (int u = 0; u < 2; u++) begin
            if (!busy[u]) m_int[u] = 1'b0;
            if (go[u]) begin m_int[u] = wr[u]; m_dst[u] = iss_idx[u]; end
        end
        m_pend = (m_pend & ~c) | s;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        go = '0; wr = '0; done = '0; ok = '0; grant = '0;
    endtask

    task automatic do_reset();
        quiet(); busy = '0;
        rst_n = 1'b0;
        m_pend = '0; m_int = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int u = 0; u < 2; u++) begin
            iss_idx[u] = '0; wb_idx[u] = '0; src_idx[u] = '0; m_dst[u] = '0;
        end
        @(negedge clk);
        do_reset();
        for (int r = 0; r < NR; r++) probe(r, "R1 after reset");

        // Sweep every destination through each release path.
        for (int r = 0; r < NR; r++) begin
            go = 2'b01; wr = 2'b01; iss_idx[0] = 3'(r);
            step(); quiet(); busy[0] = 1'b1;
            for (int q = 0; q < NR; q++) probe(q, "R2 set marks only dst");
            grant = 2'b01; wb_idx[0] = 3'(r);
            step(); quiet();
            probe(r, "R4 write port release");
            busy[0] = 1'b0; step();

            go = 2'b10; wr = 2'b10; iss_idx[1] = 3'(r);
            step(); quiet(); busy[1] = 1'b1;
            probe(r, "R2 set by unit1");
            done = 2'b10; ok = 2'b00;
            step(); quiet(); busy[1] = 1'b0;
            probe(r, "R5 no-result release");

            go = 2'b01; wr = 2'b00; iss_idx[0] = 3'(r);
            step(); quiet();
            probe(r, "R3 no write flag");
            step();
        end

        // R6: completion with result does not release through intent.
        go = 2'b01; wr = 2'b01; iss_idx[0] = 3'd5;
        step(); quiet(); busy[0] = 1'b1;
        done = 2'b01; ok = 2'b01;
        step(); quiet();
        probe(5, "R6 done with result keeps bit");
        grant = 2'b01; wb_idx[0] = 3'd5; step(); quiet(); busy[0] = 1'b0;
        probe(5, "R4 release after R6");

        // R6: intent forgotten while unit not busy.
        go = 2'b01; wr = 2'b01; iss_idx[0] = 3'd2;
        step(); quiet();
        step();
        done = 2'b01; ok = 2'b00;
        step(); quiet();
        probe(2, "R6 intent dropped when idle");
        grant = 2'b01; wb_idx[0] = 3'd2; step(); quiet();

        // R7: same-edge set and clear of one register.
        go = 2'b01; wr = 2'b01; iss_idx[0] = 3'd3;
        step(); quiet();
        go = 2'b10; wr = 2'b10; iss_idx[1] = 3'd3;
        grant = 2'b01; wb_idx[0] = 3'd3;
        step(); quiet();
        probe(3, "R7 set wins");
        grant = 2'b10; wb_idx[1] = 3'd3; step(); quiet();
        probe(3, "R7 cleared afterwards");

        // R10: two units set together, then two grants clear together.
        go = 2'b11; wr = 2'b11; iss_idx[0] = 3'd1; iss_idx[1] = 3'd6;
        step(); quiet();
        for (int q = 0; q < NR; q++) probe(q, "R10 dual set");

        // R8 / R9: check port gating with reg 1 and 6 pending.
        chk_active = 1'b0; chk_rd = 2'b11; src_idx[0] = 3'd1; src_idx[1] = 3'd6;
        #1;
        cmp(hz_b, 1'b0, "R8 inactive bin"); cmp(hz_h, 1'b0, "R8 inactive onehot");
        chk_active = 1'b1; chk_rd = 2'b00;
        #1;
        cmp(hz_b, 1'b0, "R8 no read flag bin"); cmp(hz_h, 1'b0, "R8 no read flag onehot");
        chk_rd = 2'b10; src_idx[0] = 3'd0;
        #1;
        cmp(hz_b, 1'b1, "R9 port1 hit bin"); cmp(hz_h, 1'b1, "R9 port1 hit onehot");
        chk_rd = 2'b11; src_idx[1] = 3'd7;
        #1;
        cmp(hz_b, 1'b0, "R9 both miss bin"); cmp(hz_h, 1'b0, "R9 both miss onehot");
        src_idx[0] = 3'd1;
        #1;
        cmp(hz_b, 1'b1, "R9 port0 hit bin"); cmp(hz_h, 1'b1, "R9 port0 hit onehot");
        chk_active = 1'b0; chk_rd = 2'b00;

        grant = 2'b11; wb_idx[0] = 3'd6; wb_idx[1] = 3'd1;
        step(); quiet();
        for (int q = 0; q < NR; q++) probe(q, "R10 dual clear");

        // R1: reset mid-run clears pending bits.
        go = 2'b01; wr = 2'b01; iss_idx[0] = 3'd4;
        step(); quiet();
        probe(4, "R2 before reset");
        do_reset();
        for (int q = 0; q < NR; q++) probe(q, "R1 reset mid-run");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule